// File: doc/BRIEF.md
# B-tree Node Branch Selector

This block picks the child pointer that a search through one B-tree node of a layered prefix tree follows next. A node holds up to ORDER-1 prefix keys and has ORDER child slots. The block compares a lookup address with every key of the node at once and marks each key that sorts above the address. It then keeps only the lowest such key and turns its position into a binary child index. The block runs beside the node's prefix-match logic and has the same depth, so both results for one address leave the pipeline together.

Keys are ordered so that a don't-care position sorts between 0 and 1. Each key arrives in a marker encoding that is one bit wider than the address. The address is widened by one trailing 1 bit, so a plain unsigned compare gives that ordering. Empty key slots carry a null flag and count as larger than any address. The block accepts a new address and key set every cycle. It returns the index three cycles later, with results in the same order as the inputs. Fetching the child pointer and reading node memory are done outside this block.

Top module: `bsel_node_branch`

## Requirements
- R1: Key x sorts above the address when, scanning from the most significant address bit, the first position where the key differs decides it: a key 1 over an address 0 is above, a key 0 over an address 1 is below, a key don't-care is above an address 0 and below an address 1. A full-length key equal to the address is not above it. A key is ADDR_W+1 bits wide: the prefix bits first, MSB aligned, then one 1 bit, then zeros. Key x sits at bits [x*(ADDR_W+1) +: ADDR_W+1] of in_keys.
- R2: A key whose bit in in_key_null is 1 counts as above every address, whatever its key bits hold.
- R3: out_branch is the index of the lowest-numbered key that sorts above the address.
- R4: When no key sorts above the address, out_branch is ORDER-1.
- R5: out_valid is 1 in exactly the cycle three clock edges after the edge that samples in_valid=1, and out_branch holds the result for that sample in the same cycle.
- R6: A new sample may be given on every cycle, and results come out in input order with no gaps.
- R7: While rst_n is low at a clock edge, out_valid goes to 0 and stays 0.
- R8: A cycle with in_valid=0 gives no result: out_valid stays 0 three edges later, whatever the address, keys and null flags hold.
- R9: out_branch is $clog2(ORDER) bits wide, and its value is always below ORDER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The address and key set on the inputs are a sample |
| in_addr | input | ADDR_W | Lookup address |
| in_keys | input | (ORDER-1)*(ADDR_W+1) | Marker-encoded node keys, key 0 in the low bits |
| in_key_null | input | ORDER-1 | Bit x is 1 when key slot x is empty |
| out_valid | output | 1 | out_branch holds a result |
| out_branch | output | $clog2(ORDER) | Index of the child slot to follow |

## Verification
The bench builds the block with ADDR_W=8 and ORDER=6. With an 8-bit address, random keys often share leading bits with the address and often end exactly where the address has a 0 or a 1. That exercises the don't-care-versus-bit cases of the ordering and exact full-length ties. With six child slots, the cases where every slot is null, where no slot is null, where all keys are below the address, and where the branch lands on each index are all hit often by random patterns. The bench also runs directed cases and both back-to-back and gapped traffic.

// File: rtl/bsel_pkg.sv
// Package: shared constants for the node branch selector.
// Assumes: nothing; holds only width conventions used by every stage.
package bsel_pkg;
    // Default address width (IPv4-sized lookup).
    localparam int BSEL_ADDR_W_DEF = 32;
    // Default node order (child slots per node).
    localparam int BSEL_ORDER_DEF  = 22;
    // Bit appended to the address so an unsigned compare follows 0 < * < 1.
    localparam logic BSEL_ADDR_MARK = 1'b1;

    // Width of one marker-encoded key for a given address width.
    function automatic int key_width(input int addr_w);
        return addr_w + 1;
    endfunction
endpackage

// File: rtl/bsel_cmp_stage.sv
// Module: bsel_cmp_stage
// Compares the widened address with every key slot in parallel and registers
// the greater-than vector. Null slots are forced to "greater".
// Assumes: keys in marker encoding, key x at bits [x*KEY_W +: KEY_W].
module bsel_cmp_stage
    import bsel_pkg::*;
#(
    parameter int ADDR_W = BSEL_ADDR_W_DEF,
    parameter int ORDER  = BSEL_ORDER_DEF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [ADDR_W-1:0]               in_addr,
    input  logic [(ORDER-1)*(ADDR_W+1)-1:0] in_keys,
    input  logic [ORDER-2:0]                in_key_null,
    output logic                            gt_valid,
    output logic [ORDER-2:0]                gt_vec
);
    localparam int KEY_W  = key_width(ADDR_W);
    localparam int N_KEYS = ORDER - 1;

    logic [KEY_W-1:0]  addr_ext;
    logic [N_KEYS-1:0] gt_next;

    // Widen the address with the marker bit.
    always_comb addr_ext = {in_addr, BSEL_ADDR_MARK};

    for (genvar x = 0; x < N_KEYS; x++) begin : g_cmp
        // One comparator per key slot; null slot always sorts above.
        always_comb gt_next[x] = in_key_null[x] |
                                 (in_keys[x*KEY_W +: KEY_W] > addr_ext);
    end

    // Register the greater-than vector and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gt_valid <= 1'b0;
            gt_vec   <= '0;
        end else begin
            gt_valid <= in_valid;
            gt_vec   <= gt_next;
        end
    end
endmodule

// File: rtl/bsel_onehot_stage.sv
// Module: bsel_onehot_stage
// Turns the (ORDER-1)-bit greater-than vector into an ORDER-bit one-hot
// vector marking the lowest key above the address, or the last slot if none.
// Assumes: nothing about the shape of the input vector (first-set priority).
module bsel_onehot_stage
    import bsel_pkg::*;
#(
    parameter int ORDER = BSEL_ORDER_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gt_valid,
    input  logic [ORDER-2:0] gt_vec,
    output logic             oh_valid,
    output logic [ORDER-1:0] oh_vec
);
    logic [ORDER-1:0] oh_next;

    // Priority pass: keep the first set bit, fall to the top slot if none.
    always_comb begin
        logic seen;
        seen    = 1'b0;
        oh_next = '0;
        for (int i = 0; i < ORDER - 1; i++) begin
            oh_next[i] = gt_vec[i] & ~seen;
            seen       = seen | gt_vec[i];
        end
        oh_next[ORDER-1] = ~seen;
    end

    // Register the one-hot vector and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oh_valid <= 1'b0;
            oh_vec   <= '0;
        end else begin
            oh_valid <= gt_valid;
            oh_vec   <= oh_next;
        end
    end
endmodule

// File: rtl/bsel_enc_stage.sv
// Module: bsel_enc_stage
// Encodes a one-hot vector to a binary index with an OR tree per output bit.
// Assumes: exactly one bit of the input is set when oh_valid is high.
module bsel_enc_stage
    import bsel_pkg::*;
#(
    parameter int ORDER = BSEL_ORDER_DEF,
    parameter int BR_W  = $clog2(ORDER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oh_valid,
    input  logic [ORDER-1:0] oh_vec,
    output logic             br_valid,
    output logic [BR_W-1:0]  br_idx
);
    logic [BR_W-1:0] idx_next;

    for (genvar b = 0; b < BR_W; b++) begin : g_bit
        // Output bit b is the OR of every one-hot bit whose index has bit b set.
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < ORDER; i++) begin
                if (((i >> b) & 1) == 1) acc = acc | oh_vec[i];
            end
            idx_next[b] = acc;
        end
    end

    // Register the binary index and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_valid <= 1'b0;
            br_idx   <= '0;
        end else begin
            br_valid <= oh_valid;
            br_idx   <= idx_next;
        end
    end
endmodule

// File: rtl/bsel_node_branch.sv
// Module: bsel_node_branch (top)
// Three-stage branch selector for one B-tree node: compare, one-hot, encode.
// Assumes: ORDER >= 2; keys marker encoded; null slots flagged per key.
module bsel_node_branch
    import bsel_pkg::*;
#(
    parameter int ADDR_W = BSEL_ADDR_W_DEF,
    parameter int ORDER  = BSEL_ORDER_DEF,
    parameter int BR_W   = $clog2(ORDER)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [ADDR_W-1:0]               in_addr,
    input  logic [(ORDER-1)*(ADDR_W+1)-1:0] in_keys,
    input  logic [ORDER-2:0]                in_key_null,
    output logic                            out_valid,
    output logic [BR_W-1:0]                 out_branch
);
    logic             s1_valid;
    logic [ORDER-2:0] s1_gt;
    logic             s2_valid;
    logic [ORDER-1:0] s2_oh;

    bsel_cmp_stage #(.ADDR_W(ADDR_W), .ORDER(ORDER)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_addr     (in_addr),
        .in_keys     (in_keys),
        .in_key_null (in_key_null),
        .gt_valid    (s1_valid),
        .gt_vec      (s1_gt)
    );

    bsel_onehot_stage #(.ORDER(ORDER)) u_oh (
        .clk      (clk),
        .rst_n    (rst_n),
        .gt_valid (s1_valid),
        .gt_vec   (s1_gt),
        .oh_valid (s2_valid),
        .oh_vec   (s2_oh)
    );

    bsel_enc_stage #(.ORDER(ORDER), .BR_W(BR_W)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .oh_valid (s2_valid),
        .oh_vec   (s2_oh),
        .br_valid (out_valid),
        .br_idx   (out_branch)
    );
endmodule

// File: rtl/bsel_node_branch_chk.sv
// Module: bsel_node_branch_chk
// Checker bound to bsel_node_branch: stage hand-offs, one-hot shape, range.
// Assumes: sees the top ports and the two internal stage boundaries.
module bsel_node_branch_chk #(
    parameter int ORDER = 22,
    parameter int BR_W  = $clog2(ORDER)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             s1_valid,
    input logic [ORDER-2:0] s1_gt,
    input logic             s2_valid,
    input logic [ORDER-1:0] s2_oh,
    input logic             out_valid,
    input logic [BR_W-1:0]  out_branch
);
    // R5 / R8: each stage passes valid on with exactly one edge of delay.
    p_s1_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s1_valid == $past(in_valid)));
    p_s2_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s2_valid == $past(s1_valid)));
    p_out_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(s2_valid)));

    // R3: a valid one-hot vector has exactly one bit set.
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |-> ($countones(s2_oh) == 1));

    // R4: nothing above the address selects the top slot next cycle.
    p_top_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_gt == '0)) |=> s2_oh[ORDER-1]);

    // R9: the index stays inside the node.
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_branch) < ORDER));

    // R3: the index names the bit that was set one cycle earlier.
    p_encode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(rst_n)) |-> ((($past(s2_oh) >> out_branch) & 1) == 1));

    // R7: reset clears the result flag.
    p_reset_r7: assert property (@(posedge clk)
        $past(!rst_n) |-> !out_valid);
endmodule

bind bsel_node_branch bsel_node_branch_chk #(.ORDER(ORDER), .BR_W(BR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .s1_valid   (s1_valid),
    .s1_gt      (s1_gt),
    .s2_valid   (s2_valid),
    .s2_oh      (s2_oh),
    .out_valid  (out_valid),
    .out_branch (out_branch)
);

// File: tb/sim_bsel_node_branch.sv
// Bench: scoreboard for bsel_node_branch. The driver pushes expected indices
// and issue cycles; the monitor pops and compares at every falling edge.
module sim_bsel_node_branch;
    localparam int AW    = 8;
    localparam int ORD   = 6;
    localparam int NK    = ORD - 1;
    localparam int KW    = AW + 1;
    localparam int BW    = $clog2(ORD);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [AW-1:0]       in_addr = '0;
    logic [NK*KW-1:0]    in_keys = '0;
    logic [NK-1:0]       in_key_null = '0;
    logic                out_valid;
    logic [BW-1:0]       out_branch;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    int exp_idx[$];
    int exp_cyc[$];
    string exp_tag[$];

    int k_len[NK];
    int k_val[NK];
    bit k_nul[NK];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    bsel_node_branch #(.ADDR_W(AW), .ORDER(ORD)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_keys(in_keys), .in_key_null(in_key_null),
        .out_valid(out_valid), .out_branch(out_branch)
    );

    // Record one check result.
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference ordering: bit-by-bit scan with don't-care between 0 and 1 (R1).
    function automatic bit key_above(input int len, input int val, input int addr);
        for (int p = 0; p < AW; p++) begin
            int ab;
            int kb;
            ab = (addr >> (AW - 1 - p)) & 1;
            if (p >= len) return (ab == 0);
            kb = (val >> (AW - 1 - p)) & 1;
            if (kb != ab) return (kb > ab);
        end
        return 1'b0;
    endfunction

    // Marker encoding of a prefix of length len held MSB-aligned in val.
    function automatic logic [KW-1:0] enc_key(input int len, input int val);
        logic [KW-1:0] e;
        e = '0;
        for (int p = 0; p < AW; p++)
            if (p < len) e[KW-1-p] = 1'(val >> (AW - 1 - p));
        e[KW-1-len] = 1'b1;
        return e;
    endfunction

    // Drive one sample on the next falling edge and push its expected index.
    task automatic drive(input int addr, input string tag);
        int e;
        @(negedge clk);
        e = ORD - 1;
        for (int x = NK - 1; x >= 0; x--)
            if (k_nul[x] || key_above(k_len[x], k_val[x], addr)) e = x;
        in_valid = 1'b1;
        in_addr  = AW'(addr);
        for (int x = 0; x < NK; x++) begin
            in_keys[x*KW +: KW] = enc_key(k_len[x], k_val[x]);
            in_key_null[x]      = k_nul[x];
        end
        exp_idx.push_back(e);
        exp_cyc.push_back(cyc + 3);
        exp_tag.push_back(tag);
    endtask

    // Idle cycle with scrambled keys (R8).
    task automatic idle();
        @(negedge clk);
        in_valid    = 1'b0;
        in_addr     = AW'($urandom);
        in_keys     = (NK*KW)'({$urandom, $urandom});
        in_key_null = NK'($urandom);
    endtask

    // Random prefixes sorted by the reference order, random null tail.
    task automatic rand_keys();
        int nn;
        for (int x = 0; x < NK; x++) begin
            k_len[x] = $urandom_range(0, AW);
            k_val[x] = $urandom & ((1 << AW) - 1) & ~((1 << (AW - k_len[x])) - 1);
            k_nul[x] = 1'b0;
        end
        for (int a = 0; a < NK; a++)
            for (int b = 0; b < NK - 1 - a; b++)
                if (enc_key(k_len[b], k_val[b]) > enc_key(k_len[b+1], k_val[b+1])) begin
                    int tl; int tv;
                    tl = k_len[b]; tv = k_val[b];
                    k_len[b] = k_len[b+1]; k_val[b] = k_val[b+1];
                    k_len[b+1] = tl; k_val[b+1] = tv;
                end
        nn = $urandom_range(0, NK);
        for (int x = NK - nn; x < NK; x++) k_nul[x] = 1'b1;
    endtask

    // Monitor: compare results, and flag results nobody asked for.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                int e; string t;
                e = exp_idx.pop_front();
                void'(exp_cyc.pop_front());
                t = exp_tag.pop_front();
                check(out_valid == 1'b1, {t, " R5 out_valid"}, int'(out_valid), 1);
                check(int'(out_branch) == e, t, int'(out_branch), e);
            end else if (out_valid) begin
                check(1'b0, "R8 unexpected result", 1, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R7: reset holds out_valid low even with in_valid high.
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R7 reset", int'(out_valid), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: all slots null -> slot 0.
        for (int x = 0; x < NK; x++) begin k_len[x] = AW; k_val[x] = 0; k_nul[x] = 1; end
        drive(8'hFF, "R2 all null");
        // R4: no nulls, all keys below address -> ORDER-1.
        for (int x = 0; x < NK; x++) begin k_len[x] = AW; k_val[x] = x; k_nul[x] = 0; end
        drive(8'hF0, "R4 none above");
        // R1: full-length equal key is not above; next key is.
        drive(8'h02, "R1 equal key");
        // R1: don't-care vs address 0 -> above; vs 1 -> below.
        k_len[0] = 3; k_val[0] = 8'hA0;   // 101*
        for (int x = 1; x < NK; x++) begin k_len[x] = AW; k_val[x] = 8'hFF; end
        drive(8'hA0, "R1 star over 0");
        drive(8'hB0, "R1 star over 1");
        // R1: zero-length key vs MSB.
        k_len[0] = 0; k_val[0] = 0;
        drive(8'h7F, "R1 root star over 0");
        drive(8'h80, "R1 root star over 1");
        // R2: null slot with key bits below the address still counts above.
        k_len[0] = AW; k_val[0] = 0; k_nul[0] = 1;
        drive(8'h55, "R2 null low key");
        k_nul[0] = 0; k_nul[2] = 1; k_nul[3] = 1; k_nul[4] = 1;
        k_len[1] = AW; k_val[1] = 8'h10;
        drive(8'h20, "R3 null tail");
        // R8: idle gap.
        repeat (6) idle();

        // R6: back-to-back random traffic, addresses biased toward keys.
        for (int n = 0; n < 400; n++) begin
            int a;
            rand_keys();
            a = $urandom & 8'hFF;
            if (n % 2 == 0) begin
                int s;
                s = $urandom_range(0, NK - 1);
                a = k_val[s] | (a & ((1 << (AW - k_len[s])) - 1));
            end
            drive(a, "R6 R3 random stream");
        end
        // R8: gapped random traffic.
        for (int n = 0; n < 200; n++) begin
            rand_keys();
            drive($urandom & 8'hFF, "R8 R3 gapped");
            if (n % 3 == 0) idle();
        end
        idle();
        repeat (6) @(negedge clk);
        check(exp_idx.size() == 0, "R5 queue drained", exp_idx.size(), 0);
        check(out_valid == 1'b0, "R8 quiet end", int'(out_valid), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule